// File: doc/BRIEF.md
# Packet Length Extractor and Pad Calculator

This block sits at the head of a segmentation pipeline that turns variable-length IPv4 packets into fixed 48-byte cell payloads. Packet bytes arrive one per clock with a valid strobe, a start marker on the first byte and an end marker on the last. The block passes every byte downstream unchanged, one cycle late. It also counts the header bytes in the stream and captures the 16-bit total length from the third and fourth bytes. From that length it works out how many pad bytes must be added. The target is that the packet, the padding and an 8-byte trailer together fill a whole number of cell payloads.

A small state machine walks the header. Its states are `ST_IDLE` (no packet since reset), `ST_B2`, `ST_B3` and `ST_B4` (waiting for the second, third and fourth byte), `ST_BODY` (length captured and pad count valid) and `ST_ERR` (packet too short or length too small). The transitions are:
- **start**: any state goes to `ST_B2` on an accepted start byte, or to `ST_ERR` if that byte also ends the packet.
- **advance**: `ST_B2` goes to `ST_B3` and `ST_B3` goes to `ST_B4` on an accepted byte, or to `ST_ERR` on an end byte.
- **capture**: `ST_B4` goes to `ST_BODY`, or to `ST_ERR` when the assembled length is below the minimum.
- **hold**: `ST_IDLE`, `ST_BODY` and `ST_ERR` stay where they are until the next start byte.

Top module: `pkt_len_pad`

## Requirements
- R1: After reset, out_valid, out_sop, out_eop, pad_valid and len_err are 0, and tot_len and pad_bytes are 0.
- R2: Each input byte appears on out_data one clock later, with out_valid, out_sop and out_eop equal to in_valid, in_sop and in_eop of the previous cycle.
- R3: Counting accepted bytes from the start byte as byte 1, byte 3 is the high half and byte 4 the low half of tot_len. Cycles with in_valid low are not counted.
- R4: pad_valid rises in the cycle after byte 4 is accepted and holds, with pad_bytes stable, until a start byte is accepted. It is low in the cycle after that.
- R5: While pad_valid is high, pad_bytes equals (48 - ((tot_len + 8) mod 48)) mod 48, a value from 0 to 47.
- R6: A packet whose end byte comes as byte 1, 2 or 3 sets len_err, with pad_valid low and pad_bytes 0.
- R7: A captured length below 20 sets len_err in the cycle after byte 4, with pad_valid low and pad_bytes 0. tot_len still shows the captured value.
- R8: len_err holds until the next accepted start byte and is low in the cycle after it.
- R9: Valid bytes without a start marker, while no packet has started since reset, change neither tot_len nor pad_valid nor len_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is first of packet |
| in_eop | input | 1 | Input byte is last of packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Passed-through byte valid |
| out_sop | output | 1 | Passed-through start marker |
| out_eop | output | 1 | Passed-through end marker |
| out_data | output | 8 | Passed-through byte |
| tot_len | output | 16 | Captured total length |
| pad_bytes | output | 6 | Pad byte count, 0 when not valid |
| pad_valid | output | 1 | Pad count valid for current packet |
| len_err | output | 1 | Short packet or length below minimum |

## Verification
Several properties are checked on every cycle:
- The one-cycle pass-through.
- That the pad count stays below a cell and makes length plus pad plus trailer a multiple of 48 while valid.
- That the pad-valid and error flags exclude each other, and that the error flag forces the pad count to zero.
- That both flags hold until a start byte and that a start byte clears pad-valid.

Only the bench scenarios can show that the right header bytes are taken, and that idle gaps do not shift the count. They also show the exact pad values at the ends of the length range, the early-end and small-length errors, and that stray bytes before any start marker are ignored.

// File: rtl/plp_pkg.sv
package plp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_B2,
        ST_B3,
        ST_B4,
        ST_BODY,
        ST_ERR
    } hdr_state_t;
endpackage

// File: rtl/plp_pass_pipe.sv
module plp_pass_pipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_valid,
    input  logic              i_sop,
    input  logic              i_eop,
    input  logic [DATA_W-1:0] i_data,
    output logic              o_valid,
    output logic              o_sop,
    output logic              o_eop,
    output logic [DATA_W-1:0] o_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_sop   <= 1'b0;
            o_eop   <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= i_valid;
            o_sop   <= i_valid & i_sop;
            o_eop   <= i_valid & i_eop;
            o_data  <= i_data;
        end
    end
endmodule

// File: rtl/plp_pad_calc.sv
module plp_pad_calc #(
    parameter int LEN_W       = 16,
    parameter int CELL_BYTES  = 48,
    parameter int TRAIL_BYTES = 8,
    parameter int PAD_W       = 6
) (
    input  logic [LEN_W-1:0] len,
    output logic [PAD_W-1:0] pad
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    always_comb begin
        sum = {1'b0, len} + SUM_W'(TRAIL_BYTES);
        rem = sum % SUM_W'(CELL_BYTES);
        if (rem == '0) begin
            pad = '0;
        end else begin
            pad = PAD_W'(SUM_W'(CELL_BYTES) - rem);
        end
    end
endmodule

// File: rtl/pkt_len_pad.sv
module pkt_len_pad
    import plp_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CELL_BYTES    = 48,
    parameter int TRAILER_BYTES = 8,
    parameter int MIN_LEN       = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic                          in_eop,
    input  logic [DATA_W-1:0]             in_data,
    output logic                          out_valid,
    output logic                          out_sop,
    output logic                          out_eop,
    output logic [DATA_W-1:0]             out_data,
    output logic [2*DATA_W-1:0]           tot_len,
    output logic [$clog2(CELL_BYTES)-1:0] pad_bytes,
    output logic                          pad_valid,
    output logic                          len_err
);
    localparam int LEN_W = 2 * DATA_W;
    localparam int PAD_W = $clog2(CELL_BYTES);

    hdr_state_t        state_q, state_d;
    logic [DATA_W-1:0] len_hi_q;
    logic [LEN_W-1:0]  tot_len_q;
    logic [PAD_W-1:0]  pad_q;
    logic [LEN_W-1:0]  len_now;
    logic [PAD_W-1:0]  pad_now;
    logic              sop_take;
    logic              mid_take;

    assign sop_take = in_valid & in_sop;
    assign mid_take = in_valid & ~in_sop;
    assign len_now  = {len_hi_q, in_data};

    plp_pass_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_valid (in_valid),
        .i_sop   (in_sop),
        .i_eop   (in_eop),
        .i_data  (in_data),
        .o_valid (out_valid),
        .o_sop   (out_sop),
        .o_eop   (out_eop),
        .o_data  (out_data)
    );

    plp_pad_calc #(
        .LEN_W       (LEN_W),
        .CELL_BYTES  (CELL_BYTES),
        .TRAIL_BYTES (TRAILER_BYTES),
        .PAD_W       (PAD_W)
    ) u_calc (
        .len (len_now),
        .pad (pad_now)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (sop_take) begin
            state_d = in_eop ? ST_ERR : ST_B2;
        end else if (in_valid) begin
            unique case (state_q)
                ST_B2:   state_d = in_eop ? ST_ERR : ST_B3;
                ST_B3:   state_d = in_eop ? ST_ERR : ST_B4;
                ST_B4:   state_d = (len_now < LEN_W'(MIN_LEN)) ? ST_ERR : ST_BODY;
                default: state_d = state_q;
            endcase
        end
    end

    // state register and header datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            len_hi_q  <= '0;
            tot_len_q <= '0;
            pad_q     <= '0;
        end else begin
            state_q <= state_d;
            if (mid_take && state_q == ST_B3) begin
                len_hi_q <= in_data;
            end
            if (mid_take && state_q == ST_B4) begin
                tot_len_q <= len_now;
                pad_q     <= pad_now;
            end
        end
    end

    // outputs
    always_comb begin
        tot_len   = tot_len_q;
        pad_valid = 1'b0;
        len_err   = 1'b0;
        pad_bytes = '0;
        unique case (state_q)
            ST_BODY: begin
                pad_valid = 1'b1;
                pad_bytes = pad_q;
            end
            ST_ERR:  len_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/plp_chk.sv
module plp_chk #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 48,
    parameter int TRAIL      = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          in_sop,
    input logic                          in_eop,
    input logic [DATA_W-1:0]             in_data,
    input logic                          out_valid,
    input logic                          out_sop,
    input logic                          out_eop,
    input logic [DATA_W-1:0]             out_data,
    input logic [2*DATA_W-1:0]           tot_len,
    input logic [$clog2(CELL_BYTES)-1:0] pad_bytes,
    input logic                          pad_valid,
    input logic                          len_err
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid)) && (out_data == $past(in_data))
                    && (out_sop == $past(in_valid && in_sop))
                    && (out_eop == $past(in_valid && in_eop)));

    a_r4_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_valid && !(in_valid && in_sop)) |=> (pad_valid && $stable(pad_bytes)));

    a_r4_sop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> !pad_valid);

    a_r5_pad_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pad_bytes) < CELL_BYTES);

    a_r5_whole_cells: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> ((int'(tot_len) + TRAIL + int'(pad_bytes)) % CELL_BYTES == 0));

    a_r6_err_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (pad_bytes == '0) && !pad_valid);

    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && !(in_valid && in_sop)) |=> len_err);

    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !in_eop) |=> !len_err);
endmodule

bind pkt_len_pad plp_chk #(
    .DATA_W     (DATA_W),
    .CELL_BYTES (CELL_BYTES),
    .TRAIL      (TRAILER_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .tot_len   (tot_len),
    .pad_bytes (pad_bytes),
    .pad_valid (pad_valid),
    .len_err   (len_err)
);

// File: tb/pkt_len_pad_tb.sv
`timescale 1ns/1ps
module pkt_len_pad_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_sop, out_eop;
    logic [7:0]  out_data;
    logic [15:0] tot_len;
    logic [5:0]  pad_bytes;
    logic        pad_valid, len_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pkt_len_pad u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .tot_len(tot_len), .pad_bytes(pad_bytes), .pad_valid(pad_valid),
        .len_err(len_err)
    );

    // {length, expected pad, expected error}
    localparam logic [22:0] VEC [0:7] = '{
        {16'd20,    6'd20, 1'b0},
        {16'd40,    6'd0,  1'b0},
        {16'd41,    6'd47, 1'b0},
        {16'd88,    6'd0,  1'b0},
        {16'd1500,  6'd28, 1'b0},
        {16'd65535, 6'd25, 1'b0},
        {16'd19,    6'd0,  1'b1},
        {16'd0,     6'd0,  1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic push(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_data = d; in_sop = s; in_eop = e; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 pad_valid", 32'(pad_valid), 0);
        chk("R1 len_err", 32'(len_err), 0);
        chk("R1 tot_len", 32'(tot_len), 0);
        chk("R1 pad_bytes", 32'(pad_bytes), 0);
        rst_n = 1'b1;

        // R9 stray bytes before any start marker
        push(8'h11, 0, 0); push(8'h22, 0, 0); push(8'h33, 0, 0); push(8'h44, 0, 1);
        chk("R9 tot_len", 32'(tot_len), 0);
        chk("R9 pad_valid", 32'(pad_valid), 0);
        chk("R9 len_err", 32'(len_err), 0);
        chk("R2 out_data gapped", 32'(out_data), 32'h44);

        // table walk: R3 R5 R7
        foreach (VEC[i]) begin
            push(8'h45, 1, 0);
            push(8'h00, 0, 0);
            push(VEC[i][22:15], 0, 0);
            chk("R4 not before byte 4", 32'(pad_valid), 0);
            push(VEC[i][14:7], 0, 0);
            chk("R3 tot_len", 32'(tot_len), 32'(VEC[i][22:7]));
            chk("R5 pad_bytes", 32'(pad_bytes), 32'(VEC[i][6:1]));
            chk("R4 pad_valid", 32'(pad_valid), 32'(!VEC[i][0]));
            chk("R7 len_err", 32'(len_err), 32'(VEC[i][0]));
            push(8'hA5, 0, 1);
            chk("R4 held after eop", 32'(pad_valid), 32'(!VEC[i][0]));
            chk("R8 err held", 32'(len_err), 32'(VEC[i][0]));
        end

        // R4 / R8: start byte clears flags
        push(8'h45, 1, 0);
        chk("R8 err cleared", 32'(len_err), 0);
        chk("R4 cleared", 32'(pad_valid), 0);

        // R6 end at byte 3
        push(8'h00, 0, 0);
        push(8'h05, 0, 1);
        chk("R6 len_err", 32'(len_err), 1);
        chk("R6 pad_bytes", 32'(pad_bytes), 0);
        // R6 single-byte packet
        push(8'h45, 1, 1);
        chk("R6 one byte", 32'(len_err), 1);

        // R2 / R4 back-to-back burst; bytes 3,4 = 02,03 -> length 515 -> pad 5
        for (int k = 0; k <= 6; k++) begin
            @(negedge clk);
            if (k > 0) begin
                chk("R2 out_data", 32'(out_data), 32'(k - 1));
                chk("R2 out_sop", 32'(out_sop), 32'(k == 1));
                chk("R2 out_eop", 32'(out_eop), 32'(k == 6));
            end
            if (k == 3) chk("R4 burst early", 32'(pad_valid), 0);
            if (k == 4) begin
                chk("R4 burst valid", 32'(pad_valid), 1);
                chk("R5 burst pad", 32'(pad_bytes), 5);
            end
            if (k < 6) begin
                in_valid = 1'b1; in_data = 8'(k);
                in_sop = (k == 0); in_eop = (k == 5);
            end else begin
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 out_valid idle", 32'(out_valid), 0);

        summary();
        $finish;
    end
endmodule